// File: doc/BRIEF.md
# Processor Prefix Register and Address Translator

This block holds one processor's prefix value and uses it to relocate the processor's low storage block. Every real address that the processor issues passes through the block and leaves as an absolute address. An address in block zero goes to the block the prefix names. An address in the block the prefix names goes to block zero. Every other address passes through unchanged. This lets each processor sharing one storage keep a private copy of its low fixed-use area anywhere on a block boundary.

Software loads the register with a set-prefix operation and reads it back with a store-prefix operation. The register returns to zero on four events. Two are local: initial program load and local initial program reset. Two are orders from the other processor: initial processor reset and initial program reset.

Addresses enter and leave on a valid/ready stream with no storage in between. Back-pressure passes straight through: `req_ready` follows `rsp_ready`, and `rsp_valid` follows `req_valid`. A transfer completes on a rising clock edge where both valid and ready are high. The absolute address is always formed with the prefix held in the register during that cycle.

Top module: `prefix_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the prefix register reads zero. Asserting `rst_n` low in the middle of operation also clears it.
- R2: When `pfx_wr_en` is high at a rising edge, the register takes `pfx_wr_data`. `pfx_rd_data` shows the new value from the following cycle onward.
- R3: A high `clr_load` (initial program load) or `clr_prog_rst` (local initial program reset) at a rising edge sets the register to zero.
- R4: A high `clr_remote_cpu` (initial processor reset order from the other processor) or `clr_remote_prog` (initial program reset order from the other processor) at a rising edge sets the register to zero.
- R5: When any clear input and `pfx_wr_en` are high at the same edge, the register becomes zero.
- R6: A request address whose bits 23:12 are zero leaves with bits 23:12 equal to the prefix.
- R7: When the prefix is non-zero, a request address whose bits 23:12 equal the prefix leaves with bits 23:12 equal to zero.
- R8: A request address in any other block leaves unchanged. Bits 11:0 are never altered.
- R9: When the prefix is zero, every address leaves unchanged.
- R10: The stream holds no state: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in every cycle. A new prefix applies to a request presented in the cycle right after the write edge.
- R11: With no write and no clear at an edge, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_load | input | 1 | Initial program load clear |
| clr_prog_rst | input | 1 | Local initial program reset clear |
| clr_remote_cpu | input | 1 | Initial processor reset order from the other processor |
| clr_remote_prog | input | 1 | Initial program reset order from the other processor |
| pfx_wr_en | input | 1 | Set-prefix strobe |
| pfx_wr_data | input | 12 | Prefix value to load |
| pfx_rd_data | output | 12 | Current prefix, for store-prefix |
| req_valid | input | 1 | Real address valid |
| req_ready | output | 1 | Real address accepted |
| req_addr | input | 24 | Real address |
| rsp_valid | output | 1 | Absolute address valid |
| rsp_ready | input | 1 | Downstream can take the absolute address |
| rsp_addr | output | 24 | Absolute address |

## Verification
The bench builds the block with its default parameters: 24-bit addresses and a 4096-byte block, which gives a 12-bit prefix. At that size it can place the prefix at the lowest non-zero block and at the all-ones top block, and it can drive addresses at both ends of a block's offset range. It also covers a write and a clear at the same edge, and a stalled response while the prefix is in force.

// File: rtl/prefix_pkg.sv
package prefix_pkg;
  // Order of the clear sources inside the merged vector
  localparam int CLR_LOAD        = 0;
  localparam int CLR_PROG_RST    = 1;
  localparam int CLR_REMOTE_CPU  = 2;
  localparam int CLR_REMOTE_PROG = 3;
  localparam int NUM_CLR         = 4;

  // Classification of a real address block against the prefix
  typedef enum logic [1:0] {
    BLK_LOW  = 2'd0,
    BLK_PFX  = 2'd1,
    BLK_PASS = 2'd2
  } blk_kind_e;
endpackage

// File: rtl/prefix_clear_merge.sv
module prefix_clear_merge #(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic               any_o
);
  logic [NUM_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_i[g];
  end
  assign any_o = chain[NUM_SRC];
endmodule

// File: rtl/prefix_reg.sv
module prefix_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (set_i) q_o <= set_val_i;
  end

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> (q_o == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> (q_o == $past(set_val_i)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/prefix_xlate.sv
module prefix_xlate
  import prefix_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 12,
  localparam int BLK_W = ADDR_W - OFS_W
) (
  input  logic [BLK_W-1:0]  pfx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BLK_W-1:0] in_blk;
  logic [BLK_W-1:0] out_blk;
  blk_kind_e        kind;

  always_comb begin
    in_blk = addr_i[ADDR_W-1:OFS_W];
    if (in_blk == '0)         kind = BLK_LOW;
    else if (in_blk == pfx_i) kind = BLK_PFX;
    else                      kind = BLK_PASS;
    case (kind)
      BLK_LOW: out_blk = pfx_i;
      BLK_PFX: out_blk = '0;
      default: out_blk = in_blk;
    endcase
  end

  assign addr_o = {out_blk, addr_i[OFS_W-1:0]};
endmodule

// File: rtl/prefix_unit.sv
module prefix_unit
  import prefix_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 12,
  localparam int BLK_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_load,
  input  logic              clr_prog_rst,
  input  logic              clr_remote_cpu,
  input  logic              clr_remote_prog,
  input  logic              pfx_wr_en,
  input  logic [BLK_W-1:0]  pfx_wr_data,
  output logic [BLK_W-1:0]  pfx_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic [NUM_CLR-1:0] clr_vec;
  logic               clr_any;
  logic [BLK_W-1:0]   pfx;

  assign clr_vec[CLR_LOAD]        = clr_load;
  assign clr_vec[CLR_PROG_RST]    = clr_prog_rst;
  assign clr_vec[CLR_REMOTE_CPU]  = clr_remote_cpu;
  assign clr_vec[CLR_REMOTE_PROG] = clr_remote_prog;

  prefix_clear_merge #(.NUM_SRC(NUM_CLR)) u_clr (
    .src_i (clr_vec),
    .any_o (clr_any)
  );

  prefix_reg #(.W(BLK_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_any),
    .set_i     (pfx_wr_en),
    .set_val_i (pfx_wr_data),
    .q_o       (pfx)
  );

  prefix_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_xlate (
    .pfx_i  (pfx),
    .addr_i (req_addr),
    .addr_o (rsp_addr)
  );

  assign pfx_rd_data = pfx;
  assign rsp_valid   = req_valid;
  assign req_ready   = rsp_ready;

  a_r3_local_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_load || clr_prog_rst) |=> (pfx_rd_data == '0));
  a_r4_remote_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_remote_cpu || clr_remote_prog) |=> (pfx_rd_data == '0));
  a_r6_low_to_pfx: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1:OFS_W] == '0) |->
      (rsp_addr[ADDR_W-1:OFS_W] == pfx_rd_data));
  a_r7_pfx_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pfx_rd_data != '0 && req_addr[ADDR_W-1:OFS_W] == pfx_rd_data) |->
      (rsp_addr[ADDR_W-1:OFS_W] == '0));
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (rsp_addr[OFS_W-1:0] == req_addr[OFS_W-1:0]));
  a_r10_stream_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == req_valid) && (req_ready == rsp_ready));
endmodule

// File: tb/prefix_unit_tb.sv
`timescale 1ns/1ps
module prefix_unit_tb;
  localparam int AW = 24;
  localparam int OW = 12;
  localparam int BW = AW - OW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_load = 0, clr_prog_rst = 0, clr_remote_cpu = 0, clr_remote_prog = 0;
  logic          pfx_wr_en = 0;
  logic [BW-1:0] pfx_wr_data = '0;
  logic [BW-1:0] pfx_rd_data;
  logic          req_valid = 0, req_ready, rsp_valid, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0, rsp_addr;

  int n_vec = 0;
  int n_bad = 0;
  logic [BW-1:0] model_pfx = '0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  prefix_unit #(.ADDR_W(AW), .OFS_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .clr_load(clr_load), .clr_prog_rst(clr_prog_rst),
    .clr_remote_cpu(clr_remote_cpu), .clr_remote_prog(clr_remote_prog),
    .pfx_wr_en(pfx_wr_en), .pfx_wr_data(pfx_wr_data), .pfx_rd_data(pfx_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr)
  );

  function automatic logic [AW-1:0] expect_abs(logic [AW-1:0] a, logic [BW-1:0] p);
    logic [BW-1:0] b = a[AW-1:OW];
    if (b == '0)     return {p, a[OW-1:0]};
    else if (b == p) return {{BW{1'b0}}, a[OW-1:0]};
    else             return a;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop expected absolute address on each handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected response", rsp_addr, '1);
      else begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rsp_addr, e);
      end
    end
  end

  // All tasks start and end one time unit after a rising edge
  task automatic send(input logic [AW-1:0] a, input string req);
    req_valid = 1; req_addr = a;
    exp_q.push_back(expect_abs(a, model_pfx));
    tag_q.push_back(req);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic set_pfx(input logic [BW-1:0] v);
    pfx_wr_en = 1; pfx_wr_data = v;
    @(posedge clk); #1;
    pfx_wr_en = 0; model_pfx = v;
  endtask

  task automatic pulse_clr(input int idx, input logic with_set);
    case (idx)
      0: clr_load = 1;
      1: clr_prog_rst = 1;
      2: clr_remote_cpu = 1;
      default: clr_remote_prog = 1;
    endcase
    if (with_set) begin pfx_wr_en = 1; pfx_wr_data = 12'h5A5; end
    @(posedge clk); #1;
    clr_load = 0; clr_prog_rst = 0; clr_remote_cpu = 0; clr_remote_prog = 0;
    pfx_wr_en = 0; model_pfx = '0;
  endtask

  task automatic check_pfx(input logic [BW-1:0] e, input string req);
    @(negedge clk);
    check(req, {{OW{1'b0}}, pfx_rd_data}, {{OW{1'b0}}, e});
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #12 check("R1 during reset", {{OW{1'b0}}, pfx_rd_data}, '0);
    rst_n = 1;
    @(posedge clk); #1;
    check_pfx(12'h000, "R1 after reset");
    send(24'h000123, "R9 zero prefix low block");
    send(24'h456789, "R9 zero prefix other block");
    send(24'hFFFFFF, "R9 zero prefix top");

    set_pfx(12'hABC);
    send(24'h000010, "R10 new prefix next cycle, R6");
    check_pfx(12'hABC, "R2 store-prefix reads value");
    send(24'h000FFF, "R6 low block end");
    send(24'hABC000, "R7 prefix block start");
    send(24'hABCFFF, "R7 prefix block end");
    send(24'h123456, "R8 other block");
    send(24'hABB001, "R8 neighbour block");
    @(posedge clk); #1;
    check_pfx(12'hABC, "R11 hold");

    pulse_clr(0, 0);
    check_pfx(12'h000, "R3 load clear");
    send(24'hABC777, "R9 after clear");
    set_pfx(12'h001);
    send(24'h000000, "R6 lowest prefix");
    send(24'h001ABC, "R7 lowest prefix");
    pulse_clr(1, 0);
    check_pfx(12'h000, "R3 local program reset clear");

    set_pfx(12'hFFF);
    send(24'h000777, "R6 top prefix");
    send(24'hFFF777, "R7 top prefix");
    pulse_clr(2, 0);
    check_pfx(12'h000, "R4 remote cpu reset clear");
    send(24'hFFF777, "R9 after remote clear");
    set_pfx(12'h010);
    pulse_clr(3, 0);
    check_pfx(12'h000, "R4 remote program reset clear");

    set_pfx(12'h3C3);
    pulse_clr(2, 1);
    check_pfx(12'h000, "R5 clear beats write");
    send(24'h000042, "R5 translation after collision");

    // R10 back-pressure
    set_pfx(12'h222);
    rsp_ready = 0; req_valid = 1; req_addr = 24'h000ABC;
    @(negedge clk);
    check("R10 ready follows", {23'd0, req_ready}, 24'd0);
    check("R10 valid follows", {23'd0, rsp_valid}, 24'd1);
    @(posedge clk); #1;
    exp_q.push_back(expect_abs(24'h000ABC, model_pfx));
    tag_q.push_back("R10 stalled then accepted");
    rsp_ready = 1;
    @(negedge clk);
    check("R10 ready released", {23'd0, req_ready}, 24'd1);
    @(posedge clk); #1;
    req_valid = 0;

    set_pfx(12'h333);
    rst_n = 0;
    #1 check("R1 async reset", {{OW{1'b0}}, pfx_rd_data}, '0);
    model_pfx = '0;
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    send(24'h333001, "R1 identity after reset");
    @(posedge clk); #1;
    check("R10 all responses seen", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule